// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard control for a five-stage in-order integer pipeline. It works on the instruction that sits in decode. For each of the two source operands it chooses where the value comes from: the register file, or the result of one of the three older instructions that are still in flight in the execute, memory and write-back stages. The datapath applies that choice when it loads the operand registers, so the operands are already correct before the instruction starts to execute.

Forwarding cannot cover a load followed at once by an instruction that uses its result. The block spots this case from the operand selects. It holds the program counter and the instruction register for one cycle and sends a no-op into execute instead. It also produces the cancel signals for control flow. A jump seen in decode voids the one instruction fetched after it. A branch that execute resolves as taken voids both younger instructions.

Every output is a combinational function of the current inputs. The instantiating pipeline owns the stage registers.

Top module: `hz_unit`

## Requirements
- R1: Each operand select is 2 bits, encoded as follows: 0 means the register file, 1 the execute stage, 2 the memory stage and 3 the write-back stage. When more than one stage matches, execute wins over memory, and memory wins over write-back.
- R2: A stage matches only when its write enable is 1 and its destination register equals the source register. A stage with its enable at 0 never takes part, whatever its destination.
- R3: A source register number of zero always gives select 0, even when a writing stage has destination zero.
- R4: `fwd_b` is computed from `src_b` with the same rules as `fwd_a`. Each select depends only on its own source register.
- R5: `stall` is 1 exactly when `ex_mem_read` is 1, at least one select equals 1, and no taken branch is signalled.
- R6: `bubble` is 1 whenever `stall` is 1 or a taken branch is signalled. Otherwise it is 0.
- R7: A jump in decode (`jump_dec`=1) with no stall and no taken branch sets `kill_fetch` to 1 and `kill_decode` to 0.
- R8: A taken branch (`br_taken`=1) sets both `kill_fetch` and `kill_decode` to 1. With neither a jump nor a taken branch, both kill signals are 0.
- R9: A taken branch suppresses a load-use stall that would otherwise occur in the same cycle.
- R10: While a stall is asserted, a jump in decode does not set `kill_fetch`. The held jump stays in the instruction register and is killed nowhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | AW | First source register of the decoding instruction |
| src_b | input | AW | Second source register of the decoding instruction |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| wb_dst | input | AW | Destination register of the write-back-stage instruction |
| ex_wen | input | 1 | Register-write enable of the execute-stage instruction |
| mem_wen | input | 1 | Register-write enable of the memory-stage instruction |
| wb_wen | input | 1 | Register-write enable of the write-back-stage instruction |
| ex_mem_read | input | 1 | The execute-stage instruction is a load |
| jump_dec | input | 1 | A jump is being decoded |
| br_taken | input | 1 | The execute-stage branch resolved taken |
| fwd_a | output | 2 | Source select for the first operand |
| fwd_b | output | 2 | Source select for the second operand |
| stall | output | 1 | Hold the program counter and the instruction register |
| bubble | output | 1 | Load a no-op into execute instead of the decode instruction |
| kill_fetch | output | 1 | Void the instruction fetched last |
| kill_decode | output | 1 | Void the instruction in decode |

## Verification
The assertions assume that a squashed instruction reaches this block with its write enable and its load flag already cleared. Under that assumption, a match always comes from a real older write. The assertions evaluate only once all inputs hold known values.

Random vectors draw register numbers from the values 0 to 3. This makes matches across all three stages, and multi-stage overlaps, frequent. All eight write-enable combinations occur. The load, jump and branch flags are drawn independently, so the collisions between branch and stall, and between jump and stall, also appear. Directed vectors pin down the priority order and the zero-register rule.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned FWD_STAGES = 3;
  localparam int unsigned SELW       = $clog2(FWD_STAGES + 1);

  typedef enum logic [SELW-1:0] {
    FWD_RF  = 2'd0,
    FWD_EX  = 2'd1,
    FWD_MEM = 2'd2,
    FWD_WB  = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0]                 src,
  input  logic [FWD_STAGES-1:0][AW-1:0] dst,
  input  logic [FWD_STAGES-1:0]         wen,
  output logic [SELW-1:0]               sel
);
  logic [FWD_STAGES-1:0] hit;

  // one comparator per older stage; index 0 is the nearest (execute)
  for (genvar g = 0; g < FWD_STAGES; g++) begin : g_cmp
    assign hit[g] = wen[g] && (dst[g] == src) && (src != '0);
  end

  // scan from the farthest stage so the nearest hit overrides
  always_comb begin
    sel = SELW'(FWD_RF);
    for (int i = FWD_STAGES - 1; i >= 0; i--) begin
      if (hit[i]) sel = SELW'(i + 1);
    end
  end
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
  import hz_pkg::*;
(
  input  logic            ex_mem_read,
  input  logic [SELW-1:0] sel_a,
  input  logic [SELW-1:0] sel_b,
  input  logic            br_taken,
  output logic            stall
);
  logic load_use;

  always_comb begin
    load_use = ex_mem_read &&
               ((sel_a == SELW'(FWD_EX)) || (sel_b == SELW'(FWD_EX)));
    stall    = load_use && !br_taken;
  end
endmodule

// File: rtl/hz_kill_ctl.sv
module hz_kill_ctl (
  input  logic jump_dec,
  input  logic br_taken,
  input  logic stall,
  output logic kill_fetch,
  output logic kill_decode,
  output logic bubble
);
  always_comb begin
    kill_decode = br_taken;
    kill_fetch  = br_taken || (jump_dec && !stall);
    bubble      = stall || br_taken;
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] mem_dst,
  input  logic [AW-1:0] wb_dst,
  input  logic          ex_wen,
  input  logic          mem_wen,
  input  logic          wb_wen,
  input  logic          ex_mem_read,
  input  logic          jump_dec,
  input  logic          br_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          bubble,
  output logic          kill_fetch,
  output logic          kill_decode
);
  localparam int unsigned NOPS = 2;

  logic [FWD_STAGES-1:0][AW-1:0] stg_dst;
  logic [FWD_STAGES-1:0]         stg_wen;
  logic [NOPS-1:0][AW-1:0]       op_src;
  logic [NOPS-1:0][SELW-1:0]     op_sel;

  assign stg_dst = {wb_dst, mem_dst, ex_dst};
  assign stg_wen = {wb_wen, mem_wen, ex_wen};
  assign op_src  = {src_b, src_a};

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    hz_fwd_sel #(.AW(AW)) u_sel (
      .src (op_src[o]),
      .dst (stg_dst),
      .wen (stg_wen),
      .sel (op_sel[o])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hz_stall_ctl u_stall (
    .ex_mem_read (ex_mem_read),
    .sel_a       (op_sel[0]),
    .sel_b       (op_sel[1]),
    .br_taken    (br_taken),
    .stall       (stall)
  );

  hz_kill_ctl u_kill (
    .jump_dec    (jump_dec),
    .br_taken    (br_taken),
    .stall       (stall),
    .kill_fetch  (kill_fetch),
    .kill_decode (kill_decode),
    .bubble      (bubble)
  );
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] src_a,
  input logic [AW-1:0] src_b,
  input logic [AW-1:0] ex_dst,
  input logic [AW-1:0] mem_dst,
  input logic [AW-1:0] wb_dst,
  input logic          ex_wen,
  input logic          mem_wen,
  input logic          wb_wen,
  input logic          ex_mem_read,
  input logic          jump_dec,
  input logic          br_taken,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          stall,
  input logic          bubble,
  input logic          kill_fetch,
  input logic          kill_decode
);
  logic known;

  assign known = !$isunknown({src_a, src_b, ex_dst, mem_dst, wb_dst, ex_wen,
                              mem_wen, wb_wen, ex_mem_read, jump_dec, br_taken});

  always_comb begin
    if (known) begin
      AST_EX_FIRST: assert (!(ex_wen && ex_dst == src_a && src_a != '0) || fwd_a == 2'd1); // R1
      AST_WB_NEEDS_WEN: assert (fwd_b != 2'd3 || (wb_wen && wb_dst == src_b)); // R2
      AST_ZERO_SRC: assert (src_a != '0 || fwd_a == 2'd0); // R3
      AST_STALL_IS_LOAD: assert (!stall || (ex_mem_read && (fwd_a == 2'd1 || fwd_b == 2'd1))); // R5
      AST_STALL_BUBBLES: assert (!stall || bubble); // R6
      AST_KILL_PAIR: assert (!kill_decode || kill_fetch); // R8
      AST_BRANCH_BEATS_STALL: assert (!br_taken || !stall); // R9
      AST_HELD_JUMP_LIVES: assert (!stall || !kill_fetch); // R10
    end
  end
endmodule

bind hz_unit hz_unit_chk #(.AW(AW)) u_chk (
  .src_a(src_a), .src_b(src_b), .ex_dst(ex_dst), .mem_dst(mem_dst),
  .wb_dst(wb_dst), .ex_wen(ex_wen), .mem_wen(mem_wen), .wb_wen(wb_wen),
  .ex_mem_read(ex_mem_read), .jump_dec(jump_dec), .br_taken(br_taken),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble),
  .kill_fetch(kill_fetch), .kill_decode(kill_decode)
);

// File: tb/hz_unit_tb.sv
module hz_unit_tb;
  localparam int AW = 5;

  logic clk;
  logic [AW-1:0] src_a, src_b, ex_dst, mem_dst, wb_dst;
  logic ex_wen, mem_wen, wb_wen, ex_mem_read, jump_dec, br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble, kill_fetch, kill_decode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  hz_unit #(.AW(AW)) u_dut (
    .src_a(src_a), .src_b(src_b), .ex_dst(ex_dst), .mem_dst(mem_dst),
    .wb_dst(wb_dst), .ex_wen(ex_wen), .mem_wen(mem_wen), .wb_wen(wb_wen),
    .ex_mem_read(ex_mem_read), .jump_dec(jump_dec), .br_taken(br_taken),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble),
    .kill_fetch(kill_fetch), .kill_decode(kill_decode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
    if (s == 0) return 2'd0;
    if (ex_wen && ex_dst == s) return 2'd1;
    if (mem_wen && mem_dst == s) return 2'd2;
    if (wb_wen && wb_dst == s) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic ref_stall();
    return ex_mem_read && !br_taken && (ref_sel(src_a) == 2'd1 || ref_sel(src_b) == 2'd1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] de,
                       logic [AW-1:0] dm, logic [AW-1:0] dw, logic [2:0] we,
                       logic ld, logic jp, logic bt);
    @(negedge clk);
    src_a = a; src_b = b; ex_dst = de; mem_dst = dm; wb_dst = dw;
    {wb_wen, mem_wen, ex_wen} = we;
    ex_mem_read = ld; jump_dec = jp; br_taken = bt;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all();
    logic st;
    st = ref_stall();
    chk("R1 fwd_a", int'(fwd_a), int'(ref_sel(src_a)));
    chk("R4 fwd_b", int'(fwd_b), int'(ref_sel(src_b)));
    chk("R5 stall", int'(stall), int'(st));
    chk("R6 bubble", int'(bubble), int'(st || br_taken));
    chk("R7 kill_fetch", int'(kill_fetch), int'(br_taken || (jump_dec && !st)));
    chk("R8 kill_decode", int'(kill_decode), int'(br_taken));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    drive(0, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    chk("idle R1", int'(fwd_a), 0);
    chk("idle R8", int'({kill_fetch, kill_decode, stall, bubble}), 0);

    // r1_priority: all three stages write register 4
    drive(4, 4, 4, 4, 4, 3'b111, 0, 0, 0);
    chk("R1 ex over all", int'(fwd_a), 1);
    drive(4, 4, 4, 4, 4, 3'b110, 0, 0, 0);
    chk("R1 mem over wb", int'(fwd_a), 2);
    drive(4, 4, 4, 4, 4, 3'b100, 0, 0, 0);
    chk("R1 wb only", int'(fwd_b), 3);
    // R2: matching destinations with enables off
    drive(6, 6, 6, 6, 6, 3'b000, 1, 0, 0);
    chk("R2 no enable", int'({fwd_a, fwd_b, stall}), 0);
    // R3: register zero never forwards
    drive(0, 0, 0, 0, 0, 3'b111, 1, 0, 0);
    chk("R3 zero src", int'({fwd_a, fwd_b, stall}), 0);
    // R4: operands independent
    drive(2, 5, 2, 5, 9, 3'b011, 0, 0, 0);
    chk("R4 fwd_a", int'(fwd_a), 1);
    chk("R4 fwd_b", int'(fwd_b), 2);
    // R5: load-use on second operand
    drive(3, 7, 7, 3, 0, 3'b011, 1, 0, 0);
    chk("R5 load use", int'(stall), 1);
    chk("R6 bubble on stall", int'(bubble), 1);
    // R9: taken branch cancels the stall
    drive(3, 7, 7, 3, 0, 3'b011, 1, 0, 1);
    chk("R9 no stall", int'(stall), 0);
    chk("R8 kills both", int'({kill_fetch, kill_decode}), 3);
    // R7: plain jump
    drive(1, 2, 9, 9, 9, 3'b111, 0, 1, 0);
    chk("R7 jump kill", int'({kill_fetch, kill_decode}), 2);
    // R10: jump held by a stall
    drive(8, 0, 8, 0, 0, 3'b001, 1, 1, 0);
    chk("R10 held jump", int'({stall, kill_fetch}), 2);

    for (int n = 0; n < 3000; n++) begin
      drive(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
            1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
      check_all();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule